// File: doc/BRIEF.md
# Serial Audio Data Buffer and Underflow Status

This block sits between a host bus and the serializer of a serial audio port. It keeps one receive sample word and one transmit sample word. It also keeps two status flags. The first is a data request flag that paces the host or a DMA engine. The second is a sticky underflow flag that raises an interrupt when its enable is set.

A mode input picks the direction. In receive mode, the serializer strobes in each finished sample. The request flag then says that an unread sample waits for the host. In transmit mode, the serializer strobes when it takes the next sample. The request flag then says that the host must supply a new word. If the host falls behind, the underflow flag is raised. In transmit mode the serializer then keeps getting the last word written until the host catches up.

The shifter, bit clocks and frame timing live outside this block.

Top module: `sap_data_port`

## Requirements
- R1: While `rst` is high (synchronous, active high), both flags and both data words are cleared to 0. After reset, `status`, `dma_req`, `irq`, `host_rx_data` and `ser_tx_data` all read 0.
- R2: `status` is 32 bits wide. Bit 28 is the request flag and bit 27 is the underflow flag. Bits 31..29 and 26..0 always read 0. The `dma_req` pin always equals status bit 28.
- R3: In receive mode (`mode_tx`=0), `ser_rx_valid` stores `ser_rx_data` and sets the request flag from the next cycle. A `host_rd_rx` strobe clears the flag from the next cycle. If a sample arrives in the same cycle as a read, the flag stays set.
- R4: In transmit mode (`mode_tx`=1), `ser_tx_req` sets the request flag from the next cycle. A `host_wr_tx` strobe clears the flag from the next cycle. If a write and a request happen in the same cycle, the flag ends cleared.
- R5: In receive mode, a `host_rd_rx` strobe while the request flag is 0 sets the underflow flag from the next cycle.
- R6: In transmit mode, a `ser_tx_req` strobe while the request flag is 1 sets the underflow flag from the next cycle. This also holds in the same cycle as a host write.
- R7: `ser_tx_data` shows the last word written through `host_wr_tx`, from the cycle after the write. It stays the same across any number of underflowing requests until the next write.
- R8: Once set, the underflow flag stays set whatever `uf_irq_en` is. It is cleared only by a `host_wr_stat` strobe with `host_stat_wdata` bit 27 equal to 0. Writing 1 there has no effect. When a set event and a clear happen in the same cycle, the flag ends set.
- R9: `irq` is 1 exactly when the underflow flag and `uf_irq_en` are both 1. It follows `uf_irq_en` in the same cycle.
- R10: In a cycle where `mode_tx` differs from its value in the cycle before, all serial strobes and host reads are ignored. From the next cycle the request flag is 0. Both data words keep their values.
- R11: Strobes that belong to the other mode are ignored. In transmit mode, `ser_rx_valid` and `host_rd_rx` change neither the receive word nor any flag. In receive mode, `ser_tx_req` changes no flag. `host_wr_tx` loads the transmit word in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_tx | input | 1 | 0 selects receive mode, 1 selects transmit mode |
| uf_irq_en | input | 1 | Underflow interrupt enable |
| ser_rx_valid | input | 1 | Serializer strobe: a received sample is ready |
| ser_rx_data | input | DW | Received sample |
| ser_tx_req | input | 1 | Serializer strobe: the next transmit sample is taken |
| ser_tx_data | output | DW | Transmit sample offered to the serializer |
| host_rd_rx | input | 1 | Host read strobe of the receive data word |
| host_rx_data | output | DW | Receive data word |
| host_wr_tx | input | 1 | Host write strobe of the transmit data word |
| host_tx_wdata | input | DW | Transmit data write value |
| host_wr_stat | input | 1 | Host write strobe of the status word |
| host_stat_wdata | input | 32 | Status write value; bit 27 = 0 clears underflow |
| status | output | 32 | Status word |
| dma_req | output | 1 | Data request pin |
| irq | output | 1 | Underflow interrupt |

## Verification
Every flag and data word is registered, so each strobe shows its effect one clock edge later. The only exception is `irq`, which follows `uf_irq_en` with no delay. The bench changes its inputs on the falling edge. It then waits one full cycle to the next falling edge before sampling. That way it reads exactly the state produced by the single rising edge that consumed the stimulus. Checks on `irq` after a change of `uf_irq_en` are also taken at that falling edge, because the result is combinational.

// File: rtl/sap_pkg.sv
package sap_pkg;
    localparam int STAT_W  = 32;
    localparam int DMA_BIT = 28;
    localparam int UF_BIT  = 27;

    typedef enum logic {
        MODE_RX = 1'b0,
        MODE_TX = 1'b1
    } port_mode_e;
endpackage

// File: rtl/sap_rx_slot.sv
module sap_rx_slot #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          clr,
    input  logic          smp_vld,
    input  logic [DW-1:0] smp,
    input  logic          rd,
    output logic [DW-1:0] word,
    output logic          fresh,
    output logic          uf_evt
);
    typedef struct packed {
        logic [DW-1:0] word;
        logic          fresh;
    } rx_st_t;

    rx_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        uf_evt = en && rd && !st_q.fresh;
        if (en && smp_vld) begin
            st_d.word = smp;
        end
        if (clr) begin
            st_d.fresh = 1'b0;
        end else if (en) begin
            if (smp_vld) begin
                st_d.fresh = 1'b1;
            end else if (rd) begin
                st_d.fresh = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word  = st_q.word;
    assign fresh = st_q.fresh;
endmodule

// File: rtl/sap_tx_slot.sv
module sap_tx_slot #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          clr,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          req,
    output logic [DW-1:0] word,
    output logic          need,
    output logic          uf_evt
);
    typedef struct packed {
        logic [DW-1:0] word;
        logic          need;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        uf_evt = en && req && st_q.need;
        if (wr) begin
            st_d.word = wdata;
        end
        if (clr) begin
            st_d.need = 1'b0;
        end else if (en) begin
            if (wr) begin
                st_d.need = 1'b0;
            end else if (req) begin
                st_d.need = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.word;
    assign need = st_q.need;
endmodule

// File: rtl/sap_flag_ctl.sv
module sap_flag_ctl (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_wr,
    input  logic clr_val,
    input  logic ie,
    output logic uf,
    output logic irq
);
    typedef struct packed {
        logic uf;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_evt) begin
            st_d.uf = 1'b1;
        end else if (clr_wr && !clr_val) begin
            st_d.uf = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign uf  = st_q.uf;
    assign irq = st_q.uf && ie;
endmodule

// File: rtl/sap_data_port.sv
module sap_data_port
    import sap_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_tx,
    input  logic              uf_irq_en,
    input  logic              ser_rx_valid,
    input  logic [DW-1:0]     ser_rx_data,
    input  logic              ser_tx_req,
    output logic [DW-1:0]     ser_tx_data,
    input  logic              host_rd_rx,
    output logic [DW-1:0]     host_rx_data,
    input  logic              host_wr_tx,
    input  logic [DW-1:0]     host_tx_wdata,
    input  logic              host_wr_stat,
    input  logic [STAT_W-1:0] host_stat_wdata,
    output logic [STAT_W-1:0] status,
    output logic              dma_req,
    output logic              irq
);
    typedef struct packed {
        port_mode_e mode;
    } top_st_t;

    top_st_t st_d, st_q;

    port_mode_e mode_in;
    logic       mode_chg;
    logic       rx_en, tx_en;
    logic       rx_fresh, tx_need;
    logic       rx_uf, tx_uf;
    logic       uf_flag;

    assign mode_in = port_mode_e'(mode_tx);

    always_comb begin
        st_d      = st_q;
        st_d.mode = mode_in;
        mode_chg  = (mode_in != st_q.mode);
        rx_en     = !mode_chg && (st_q.mode == MODE_RX);
        tx_en     = !mode_chg && (st_q.mode == MODE_TX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode <= mode_in;
        end else begin
            st_q <= st_d;
        end
    end

    sap_rx_slot #(.DW(DW)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .en      (rx_en),
        .clr     (mode_chg),
        .smp_vld (ser_rx_valid),
        .smp     (ser_rx_data),
        .rd      (host_rd_rx),
        .word    (host_rx_data),
        .fresh   (rx_fresh),
        .uf_evt  (rx_uf)
    );

    sap_tx_slot #(.DW(DW)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .en      (tx_en),
        .clr     (mode_chg),
        .wr      (host_wr_tx),
        .wdata   (host_tx_wdata),
        .req     (ser_tx_req),
        .word    (ser_tx_data),
        .need    (tx_need),
        .uf_evt  (tx_uf)
    );

    sap_flag_ctl u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_evt (rx_uf || tx_uf),
        .clr_wr  (host_wr_stat),
        .clr_val (host_stat_wdata[UF_BIT]),
        .ie      (uf_irq_en),
        .uf      (uf_flag),
        .irq     (irq)
    );

    assign dma_req = (st_q.mode == MODE_TX) ? tx_need : rx_fresh;

    for (genvar b = 0; b < STAT_W; b++) begin : g_stat
        if (b == DMA_BIT) begin : g_dma
            assign status[b] = dma_req;
        end else if (b == UF_BIT) begin : g_uf
            assign status[b] = uf_flag;
        end else begin : g_zero
            assign status[b] = 1'b0;
        end
    end
endmodule

// File: rtl/sap_data_port_chk.sv
module sap_data_port_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          mode_tx,
    input logic          uf_irq_en,
    input logic          ser_rx_valid,
    input logic          ser_tx_req,
    input logic [DW-1:0] ser_tx_data,
    input logic          host_rd_rx,
    input logic          host_wr_tx,
    input logic          host_wr_stat,
    input logic [31:0]   host_stat_wdata,
    input logic [31:0]   status,
    input logic          dma_req,
    input logic          irq
);
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (status[31:29] == 3'b000) && (status[26:0] == '0)); // R2

    AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!mode_tx && host_rd_rx && !ser_rx_valid) |=> !dma_req); // R3

    AST_TX_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (mode_tx && host_wr_tx) |=> !dma_req); // R4

    AST_RX_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (!mode_tx && $stable(mode_tx) && host_rd_rx && !dma_req) |=> status[27]); // R5

    AST_TX_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (mode_tx && $stable(mode_tx) && ser_tx_req && dma_req) |=> status[27]); // R6

    AST_TX_REPEAT: assert property (@(posedge clk) disable iff (rst)
        (ser_tx_req && !host_wr_tx) |=> $stable(ser_tx_data)); // R7

    AST_UF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status[27] && !(host_wr_stat && !host_stat_wdata[27])) |=> status[27]); // R8

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq |-> (uf_irq_en && status[27])); // R9

    AST_MODE_CHANGE_DROP: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_tx) |=> !dma_req); // R10
endmodule

bind sap_data_port sap_data_port_chk #(.DW(DW)) i_chk (
    .clk             (clk),
    .rst             (rst),
    .mode_tx         (mode_tx),
    .uf_irq_en       (uf_irq_en),
    .ser_rx_valid    (ser_rx_valid),
    .ser_tx_req      (ser_tx_req),
    .ser_tx_data     (ser_tx_data),
    .host_rd_rx      (host_rd_rx),
    .host_wr_tx      (host_wr_tx),
    .host_wr_stat    (host_wr_stat),
    .host_stat_wdata (host_stat_wdata),
    .status          (status),
    .dma_req         (dma_req),
    .irq             (irq)
);

// File: tb/test_sap_data_port.sv
module test_sap_data_port;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          mode_tx, uf_irq_en;
    logic          ser_rx_valid, ser_tx_req;
    logic [DW-1:0] ser_rx_data, ser_tx_data;
    logic          host_rd_rx, host_wr_tx, host_wr_stat;
    logic [DW-1:0] host_rx_data, host_tx_wdata;
    logic [31:0]   host_stat_wdata, status;
    logic          dma_req, irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sap_data_port #(.DW(DW)) i_sap_data_port (
        .clk(clk), .rst(rst), .mode_tx(mode_tx), .uf_irq_en(uf_irq_en),
        .ser_rx_valid(ser_rx_valid), .ser_rx_data(ser_rx_data),
        .ser_tx_req(ser_tx_req), .ser_tx_data(ser_tx_data),
        .host_rd_rx(host_rd_rx), .host_rx_data(host_rx_data),
        .host_wr_tx(host_wr_tx), .host_tx_wdata(host_tx_wdata),
        .host_wr_stat(host_wr_stat), .host_stat_wdata(host_stat_wdata),
        .status(status), .dma_req(dma_req), .irq(irq)
    );

    function automatic logic [31:0] stat_of(input logic d, input logic u);
        return {3'b000, d, u, 27'd0};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        ser_rx_valid = 0; ser_tx_req = 0; host_rd_rx = 0;
        host_wr_tx = 0; host_wr_stat = 0;
    endtask

    // inputs are held for one rising edge, then results are sampled at the next falling edge
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic clear_uf();
        host_wr_stat = 1; host_stat_wdata = 32'h0;
        step();
    endtask

    task automatic t_reset();
        rst = 1; mode_tx = 0; uf_irq_en = 0; idle();
        ser_rx_data = '0; host_tx_wdata = '0; host_stat_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 status", status, 32'h0);
        chk("R1 dma_req", dma_req, 0);
        chk("R1 irq", irq, 0);
        chk("R1 rx word", host_rx_data, 0);
        chk("R1 tx word", ser_tx_data, 0);
    endtask

    task automatic t_rx_basic();
        ser_rx_valid = 1; ser_rx_data = 32'hA5A5_0001;
        step();
        chk("R3 set status", status, stat_of(1, 0));
        chk("R2 pin", dma_req, status[28]);
        chk("R3 word", host_rx_data, 32'hA5A5_0001);
        host_rd_rx = 1;
        step();
        chk("R3 read clears", status, stat_of(0, 0));
        ser_rx_valid = 1; ser_rx_data = 32'h0000_0002;
        step();
        ser_rx_valid = 1; ser_rx_data = 32'h0000_0003; host_rd_rx = 1;
        step();
        chk("R3 arrival beats read", status, stat_of(1, 0));
        chk("R3 word new", host_rx_data, 32'h0000_0003);
        host_rd_rx = 1;
        step();
    endtask

    task automatic t_rx_underflow();
        host_rd_rx = 1;
        step();
        chk("R5 uf set", status, stat_of(0, 1));
        chk("R9 irq off when disabled", irq, 0);
        uf_irq_en = 1;
        #1;
        chk("R9 irq on", irq, 1);
        host_wr_stat = 1; host_stat_wdata = 32'hFFFF_FFFF;
        step();
        chk("R8 write one no effect", status[27], 1);
        host_wr_stat = 1; host_stat_wdata = 32'hF7FF_FFFF;
        step();
        chk("R8 write zero clears", status[27], 0);
        chk("R9 irq off", irq, 0);
        host_rd_rx = 1; host_wr_stat = 1; host_stat_wdata = 32'h0;
        step();
        chk("R8 set beats clear", status[27], 1);
        uf_irq_en = 0;
        #1;
        chk("R9 irq follows enable", irq, 0);
        clear_uf();
    endtask

    task automatic t_mode_switch_to_tx();
        ser_rx_valid = 1; ser_rx_data = 32'h0000_0044;
        step();
        mode_tx = 1; ser_tx_req = 1;
        step();
        chk("R10 flag dropped", dma_req, 0);
        chk("R10 rx word kept", host_rx_data, 32'h0000_0044);
    endtask

    task automatic t_tx_flow();
        host_wr_tx = 1; host_tx_wdata = 32'h1234_0000;
        step();
        chk("R7 word shown", ser_tx_data, 32'h1234_0000);
        chk("R4 no request yet", status, stat_of(0, 0));
        ser_tx_req = 1;
        step();
        chk("R4 request set", status, stat_of(1, 0));
        ser_tx_req = 1;
        step();
        chk("R6 underflow", status, stat_of(1, 1));
        chk("R7 repeat", ser_tx_data, 32'h1234_0000);
        ser_tx_req = 1;
        step();
        chk("R7 repeat again", ser_tx_data, 32'h1234_0000);
        host_wr_tx = 1; host_tx_wdata = 32'h5678_0000;
        step();
        chk("R4 write clears", status, stat_of(0, 1));
        chk("R7 new word", ser_tx_data, 32'h5678_0000);
        clear_uf();
        ser_tx_req = 1;
        step();
        chk("R6 no uf when served", status, stat_of(1, 0));
        ser_tx_req = 1; host_wr_tx = 1; host_tx_wdata = 32'h9ABC_0000;
        step();
        chk("R4 write beats request", dma_req, 0);
        chk("R6 same cycle uf", status[27], 1);
        clear_uf();
    endtask

    task automatic t_other_mode();
        ser_rx_valid = 1; ser_rx_data = 32'hDEAD_0000; host_rd_rx = 1;
        step();
        chk("R11 rx ignored in tx", host_rx_data, 32'h0000_0044);
        chk("R11 no flags in tx", status, stat_of(0, 0));
        ser_tx_req = 1;
        step();
        mode_tx = 0;
        step();
        chk("R10 tx flag dropped", status, stat_of(0, 0));
        chk("R10 tx word kept", ser_tx_data, 32'h9ABC_0000);
        ser_tx_req = 1;
        step();
        chk("R11 tx req ignored in rx", status, stat_of(0, 0));
        host_wr_tx = 1; host_tx_wdata = 32'h0000_0077;
        step();
        chk("R11 tx word loads in rx", ser_tx_data, 32'h0000_0077);
        chk("R11 rx flag untouched", dma_req, 0);
    endtask

    initial begin
        t_reset();
        t_rx_basic();
        t_rx_underflow();
        t_mode_switch_to_tx();
        t_tx_flow();
        t_other_mode();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule